// File: doc/BRIEF.md
# Stream Context Command Handler

This block sits behind a byte-wide control channel and manages a small table of per-stream offload contexts. Each message arrives one byte per transfer on a valid/ready input, and its final byte carries an end-of-message marker. The first byte selects the command: open a stream, or close one. The next four bytes carry a 32-bit stream identifier, most significant byte first. An open command then carries a fixed 148-byte payload. The block picks out the connection, record and key fields from this payload, assembles each one big-endian, and writes them into a table entry keyed by the identifier.

After it has stored an open command, the block sends back an 8-byte acknowledgement on a valid/ready output. A close command marks the matching entry unused and sends nothing back. While an acknowledgement is pending, input is held off.

A datapath elsewhere presents an identifier on the lookup port. In the same cycle it gets back a hit indication and the stored fields. Three sticky error flags report these events: a table overflow, a close for an identifier that is not in the table, and a malformed or unrecognised message. Each flag clears only on reset.

Top module: `stream_ctx_handler`

## Requirements
- R1: Byte 0 of a message is the command code: 0x01 opens a stream and 0x02 closes one. Bytes 1 to 4 are the stream identifier, most significant byte first, with no padding. A later lookup with that 32-bit value hits.
- R2: An open message is 153 bytes long, with the marker on byte 152. Payload index p means message byte p+5. The table stores these payload fields, each assembled most significant byte first: source port at p20..21, destination port at p22..23, TCP sequence at p28..31, record sequence at p48..55, next expected sequence at p60..63, implicit IV at p64..67, and key at p116..147.
- R3: After an open is stored, the output sends exactly 8 bytes: 0x00 0x00 0x00 0x81, then the identifier most significant byte first. The marker is set on the 8th byte only.
- R4: An output byte and its marker stay unchanged until they are accepted. in_ready is 0 while an acknowledgement is pending.
- R5: A close message is 5 bytes long, with the marker on byte 4. It sends no acknowledgement, and afterwards a lookup of that identifier misses.
- R6: An open for an identifier already in the table overwrites that entry and does not take a second one.
- R7: The table holds N_ENTRIES (default 8) entries. An open that finds neither a matching entry nor a free one still sends its acknowledgement, stores nothing, and sets err_full.
- R8: A close for an identifier not in the table changes no entry and sets err_unknown_id.
- R9: Any other command code sets err_msg. The block then discards bytes up to and including the marker, and parses the next message normally.
- R10: lk_flags is the low nibble of payload byte p19: bit 3 is TCP (0 means UDP), bit 2 is initialised, bit 1 is valid, and bit 0 is IPv6 (0 means IPv4). lk_tls_ver is the upper nibble of payload byte p59, where 3 means TLS 1.2.
- R11: After reset, in_ready is 1, rsp_valid is 0, all error flags are 0, and every lookup misses.
- R12: A marker that arrives before the expected final byte ends the message without storing it or acknowledging it, and sets err_msg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input message byte |
| in_last | input | 1 | End-of-message marker on the current byte |
| rsp_valid | output | 1 | Acknowledgement byte valid |
| rsp_ready | input | 1 | Consumer accepts the acknowledgement byte |
| rsp_data | output | 8 | Acknowledgement byte |
| rsp_last | output | 1 | Final byte of the acknowledgement |
| lk_id | input | 32 | Identifier to look up |
| lk_hit | output | 1 | Lookup found a used entry |
| lk_flags | output | 4 | Stored connection flags |
| lk_src_port | output | 16 | Stored source port |
| lk_dst_port | output | 16 | Stored destination port |
| lk_tcp_sn | output | 32 | Stored TCP sequence number |
| lk_rec_sn | output | 64 | Stored record sequence number |
| lk_tls_ver | output | 4 | Stored protocol version nibble |
| lk_next_sn | output | 32 | Stored next expected TCP sequence |
| lk_iv | output | 32 | Stored implicit IV |
| lk_key | output | 256 | Stored key |
| err_full | output | 1 | Sticky: an open found no room |
| err_unknown_id | output | 1 | Sticky: a close named an absent identifier |
| err_msg | output | 1 | Sticky: bad command code or wrong length |

## Verification
The checker watches the output handshake on every cycle. It checks that a stalled byte and its marker hold still, that in_ready stays low while an acknowledgement is out, that each acknowledgement starts with a zero byte and ends after its marked byte, and that all three error flags stay set once raised. Other behaviour depends on the history of earlier messages, so only the bench's scenarios can show it. This covers the field offsets, the identifier echo, overwriting an existing entry without using a second slot, overflow after exactly the table depth, the silent close, and recovery after a bad command code or a short message.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam logic [7:0] OP_OPEN      = 8'h01;
   localparam logic [7:0] OP_CLOSE     = 8'h02;
   localparam logic [7:0] RSP_OPEN_ACK = 8'h81;

   // payload byte offsets (payload index 0 is message byte 5)
   localparam logic [7:0] PAY_LAST    = 8'd147;
   localparam logic [7:0] OFF_FLAGS   = 8'd19;
   localparam logic [7:0] OFF_SPORT   = 8'd20;
   localparam logic [7:0] OFF_DPORT   = 8'd22;
   localparam logic [7:0] OFF_TCPSN   = 8'd28;
   localparam logic [7:0] OFF_RECSN   = 8'd48;
   localparam logic [7:0] OFF_TYPEVER = 8'd59;
   localparam logic [7:0] OFF_NEXTSN  = 8'd60;
   localparam logic [7:0] OFF_IV      = 8'd64;
   localparam logic [7:0] OFF_KEY     = 8'd116;

   typedef struct packed {
      logic [3:0]   flags;
      logic [15:0]  sport;
      logic [15:0]  dport;
      logic [31:0]  tcp_sn;
      logic [63:0]  rec_sn;
      logic [3:0]   ver;
      logic [31:0]  next_sn;
      logic [31:0]  iv;
      logic [255:0] key;
   } ctx_t;

   typedef enum logic [1:0] {PS_OP, PS_ID, PS_PAY, PS_DRAIN} pstate_t;

   function automatic logic in_rng(input logic [7:0] c, input logic [7:0] off,
                                   input logic [7:0] len);
      return (c >= off) && (c < off + len);
   endfunction
endpackage

// File: rtl/sc_msg_parser.sv
module sc_msg_parser
   import sc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   input  logic        in_last,
   input  logic        hold,
   output logic        in_ready,
   output logic        open_go,
   output logic        close_go,
   output logic        msg_err,
   output logic [31:0] cmd_id,
   output ctx_t        cmd_ctx
);
   pstate_t    st;
   logic [7:0] cnt;
   logic       is_open;
   logic       acc;
   logic       cap;

   assign in_ready = !hold;
   assign acc      = in_valid && in_ready;
   assign cap      = acc && (st == PS_PAY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= PS_OP;
         cnt      <= '0;
         is_open  <= 1'b0;
         cmd_id   <= '0;
         open_go  <= 1'b0;
         close_go <= 1'b0;
         msg_err  <= 1'b0;
      end else begin
         open_go  <= 1'b0;
         close_go <= 1'b0;
         msg_err  <= 1'b0;
         if (acc) begin
            unique case (st)
               PS_OP: begin
                  cnt <= '0;
                  if (in_data == OP_OPEN || in_data == OP_CLOSE) begin
                     is_open <= (in_data == OP_OPEN);
                     if (in_last) msg_err <= 1'b1;
                     else         st      <= PS_ID;
                  end else begin
                     msg_err <= 1'b1;
                     if (!in_last) st <= PS_DRAIN;
                  end
               end
               PS_ID: begin
                  cmd_id <= {cmd_id[23:0], in_data};
                  cnt    <= cnt + 8'd1;
                  if (cnt == 8'd3) begin
                     if (is_open) begin
                        if (in_last) begin
                           msg_err <= 1'b1;
                           st      <= PS_OP;
                        end else begin
                           st  <= PS_PAY;
                           cnt <= '0;
                        end
                     end else if (in_last) begin
                        close_go <= 1'b1;
                        st       <= PS_OP;
                     end else begin
                        msg_err <= 1'b1;
                        st      <= PS_DRAIN;
                     end
                  end else if (in_last) begin
                     msg_err <= 1'b1;
                     st      <= PS_OP;
                  end
               end
               PS_PAY: begin
                  cnt <= cnt + 8'd1;
                  if (cnt == PAY_LAST) begin
                     if (in_last) begin
                        open_go <= 1'b1;
                        st      <= PS_OP;
                     end else begin
                        msg_err <= 1'b1;
                        st      <= PS_DRAIN;
                     end
                  end else if (in_last) begin
                     msg_err <= 1'b1;
                     st      <= PS_OP;
                  end
               end
               PS_DRAIN: begin
                  if (in_last) st <= PS_OP;
               end
            endcase
         end
      end
   end

   // payload field capture, each field shifted in most significant byte first
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_ctx <= '0;
      end else if (cap) begin
         if (cnt == OFF_FLAGS)               cmd_ctx.flags   <= in_data[3:0];
         if (cnt == OFF_TYPEVER)             cmd_ctx.ver     <= in_data[7:4];
         if (in_rng(cnt, OFF_SPORT,  8'd2))  cmd_ctx.sport   <= {cmd_ctx.sport[7:0], in_data};
         if (in_rng(cnt, OFF_DPORT,  8'd2))  cmd_ctx.dport   <= {cmd_ctx.dport[7:0], in_data};
         if (in_rng(cnt, OFF_TCPSN,  8'd4))  cmd_ctx.tcp_sn  <= {cmd_ctx.tcp_sn[23:0], in_data};
         if (in_rng(cnt, OFF_RECSN,  8'd8))  cmd_ctx.rec_sn  <= {cmd_ctx.rec_sn[55:0], in_data};
         if (in_rng(cnt, OFF_NEXTSN, 8'd4))  cmd_ctx.next_sn <= {cmd_ctx.next_sn[23:0], in_data};
         if (in_rng(cnt, OFF_IV,     8'd4))  cmd_ctx.iv      <= {cmd_ctx.iv[23:0], in_data};
         if (in_rng(cnt, OFF_KEY,    8'd32)) cmd_ctx.key     <= {cmd_ctx.key[247:0], in_data};
      end
   end
endmodule

// File: rtl/sc_ctx_table.sv
module sc_ctx_table
   import sc_pkg::*;
#(
   parameter int N_ENTRIES  = 8,
   parameter bit REG_LOOKUP = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_open,
   input  logic        wr_close,
   input  logic [31:0] cmd_id,
   input  ctx_t        cmd_ctx,
   input  logic [31:0] lk_id,
   output logic        lk_hit,
   output ctx_t        lk_ctx,
   output logic        full_err,
   output logic        unknown_err
);
   localparam int SLOT_W = $clog2(N_ENTRIES);

   if (N_ENTRIES < 2 || N_ENTRIES > 64) begin : g_bad_depth
      $error("sc_ctx_table: N_ENTRIES must lie in 2..64");
   end

   logic [N_ENTRIES-1:0] used;
   logic [31:0]          id_r  [N_ENTRIES];
   ctx_t                 ctx_r [N_ENTRIES];
   logic [N_ENTRIES-1:0] cmd_vec, lk_vec, wr_en, clr_en;
   logic [SLOT_W-1:0]    hit_slot, free_slot;
   logic                 any_hit, any_free;
   logic                 lk_hit_c;
   ctx_t                 lk_ctx_c;

   assign any_hit  = |cmd_vec;
   assign any_free = ~&used;

   always_comb begin
      hit_slot  = '0;
      free_slot = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (cmd_vec[i]) hit_slot  = SLOT_W'(i);
         if (!used[i])   free_slot = SLOT_W'(i);
      end
   end

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      assign cmd_vec[g] = used[g] && (id_r[g] == cmd_id);
      assign lk_vec[g]  = used[g] && (id_r[g] == lk_id);
      assign wr_en[g]   = wr_open && (any_hit ? (hit_slot == SLOT_W'(g))
                                              : (any_free && free_slot == SLOT_W'(g)));
      assign clr_en[g]  = wr_close && cmd_vec[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used        <= '0;
         full_err    <= 1'b0;
         unknown_err <= 1'b0;
         for (int i = 0; i < N_ENTRIES; i++) begin
            id_r[i]  <= '0;
            ctx_r[i] <= '0;
         end
      end else begin
         for (int i = 0; i < N_ENTRIES; i++) begin
            if (wr_en[i]) begin
               used[i]  <= 1'b1;
               id_r[i]  <= cmd_id;
               ctx_r[i] <= cmd_ctx;
            end else if (clr_en[i]) begin
               used[i] <= 1'b0;
            end
         end
         if (wr_open && !any_hit && !any_free) full_err    <= 1'b1;
         if (wr_close && !any_hit)             unknown_err <= 1'b1;
      end
   end

   always_comb begin
      lk_ctx_c = '0;
      for (int i = 0; i < N_ENTRIES; i++)
         if (lk_vec[i]) lk_ctx_c = ctx_r[i];
   end
   assign lk_hit_c = |lk_vec;

   if (REG_LOOKUP) begin : g_lk_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lk_hit <= 1'b0;
            lk_ctx <= '0;
         end else begin
            lk_hit <= lk_hit_c;
            lk_ctx <= lk_ctx_c;
         end
      end
   end else begin : g_lk_comb
      assign lk_hit = lk_hit_c;
      assign lk_ctx = lk_ctx_c;
   end
endmodule

// File: rtl/sc_rsp_gen.sv
module sc_rsp_gen
   import sc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [31:0] start_id,
   input  logic        rsp_ready,
   output logic        rsp_valid,
   output logic [7:0]  rsp_data,
   output logic        rsp_last
);
   logic [2:0]  idx;
   logic [31:0] id_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         idx       <= '0;
         id_r      <= '0;
      end else if (start) begin
         rsp_valid <= 1'b1;
         idx       <= '0;
         id_r      <= start_id;
      end else if (rsp_valid && rsp_ready) begin
         if (idx == 3'd7) rsp_valid <= 1'b0;
         idx <= idx + 3'd1;
      end
   end

   always_comb begin
      unique case (idx)
         3'd3:    rsp_data = RSP_OPEN_ACK;
         3'd4:    rsp_data = id_r[31:24];
         3'd5:    rsp_data = id_r[23:16];
         3'd6:    rsp_data = id_r[15:8];
         3'd7:    rsp_data = id_r[7:0];
         default: rsp_data = 8'h00;
      endcase
   end

   assign rsp_last = rsp_valid && (idx == 3'd7);
endmodule

// File: rtl/stream_ctx_handler.sv
module stream_ctx_handler
   import sc_pkg::*;
#(
   parameter int N_ENTRIES  = 8,
   parameter bit REG_LOOKUP = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [7:0]   in_data,
   input  logic         in_last,
   output logic         rsp_valid,
   input  logic         rsp_ready,
   output logic [7:0]   rsp_data,
   output logic         rsp_last,
   input  logic [31:0]  lk_id,
   output logic         lk_hit,
   output logic [3:0]   lk_flags,
   output logic [15:0]  lk_src_port,
   output logic [15:0]  lk_dst_port,
   output logic [31:0]  lk_tcp_sn,
   output logic [63:0]  lk_rec_sn,
   output logic [3:0]   lk_tls_ver,
   output logic [31:0]  lk_next_sn,
   output logic [31:0]  lk_iv,
   output logic [255:0] lk_key,
   output logic         err_full,
   output logic         err_unknown_id,
   output logic         err_msg
);
   logic        open_go, close_go, msg_err_p, hold;
   logic [31:0] cmd_id;
   ctx_t        cmd_ctx, lk_ctx;

   // no input while a command is being committed or acknowledged
   assign hold = rsp_valid || open_go || close_go;

   sc_msg_parser u_parse (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .hold(hold), .in_ready(in_ready), .open_go(open_go),
      .close_go(close_go), .msg_err(msg_err_p), .cmd_id(cmd_id), .cmd_ctx(cmd_ctx)
   );

   sc_ctx_table #(.N_ENTRIES(N_ENTRIES), .REG_LOOKUP(REG_LOOKUP)) u_tab (
      .clk(clk), .rst_n(rst_n), .wr_open(open_go), .wr_close(close_go),
      .cmd_id(cmd_id), .cmd_ctx(cmd_ctx), .lk_id(lk_id), .lk_hit(lk_hit),
      .lk_ctx(lk_ctx), .full_err(err_full), .unknown_err(err_unknown_id)
   );

   sc_rsp_gen u_rsp (
      .clk(clk), .rst_n(rst_n), .start(open_go), .start_id(cmd_id),
      .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_last(rsp_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         err_msg <= 1'b0;
      else if (msg_err_p) err_msg <= 1'b1;
   end

   assign lk_flags    = lk_ctx.flags;
   assign lk_src_port = lk_ctx.sport;
   assign lk_dst_port = lk_ctx.dport;
   assign lk_tcp_sn   = lk_ctx.tcp_sn;
   assign lk_rec_sn   = lk_ctx.rec_sn;
   assign lk_tls_ver  = lk_ctx.ver;
   assign lk_next_sn  = lk_ctx.next_sn;
   assign lk_iv       = lk_ctx.iv;
   assign lk_key      = lk_ctx.key;
endmodule

// File: rtl/sc_handler_chk.sv
module sc_handler_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_ready,
   input logic       rsp_valid,
   input logic       rsp_ready,
   input logic [7:0] rsp_data,
   input logic       rsp_last,
   input logic       err_full,
   input logic       err_unknown_id,
   input logic       err_msg
);
   a_r4_ready_low_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !in_ready);

   a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

   a_r3_first_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> (rsp_data == 8'h00 && !rsp_last));

   a_r3_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready && rsp_last) |=> !rsp_valid);

   a_r7_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_full |=> err_full);

   a_r8_unknown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_unknown_id |=> err_unknown_id);

   a_r9_msg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_msg |=> err_msg);
endmodule

bind stream_ctx_handler sc_handler_chk u_chk (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .rsp_valid(rsp_valid),
   .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
   .err_full(err_full), .err_unknown_id(err_unknown_id), .err_msg(err_msg)
);

// File: tb/stream_ctx_handler_test.sv
module stream_ctx_handler_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0, in_last = 1'b0, rsp_ready = 1'b0;
   logic [7:0]   in_data = 8'h00;
   logic [31:0]  lk_id = 32'h0;
   logic         in_ready, rsp_valid, rsp_last, lk_hit;
   logic [7:0]   rsp_data;
   logic [3:0]   lk_flags, lk_tls_ver;
   logic [15:0]  lk_src_port, lk_dst_port;
   logic [31:0]  lk_tcp_sn, lk_next_sn, lk_iv;
   logic [63:0]  lk_rec_sn;
   logic [255:0] lk_key;
   logic         err_full, err_unknown_id, err_msg;
   int           n_chk = 0, n_fail = 0;
   bit           done = 1'b0;
   int           cyc = 0;

   always #4 clk = ~clk;

   stream_ctx_handler uut (.*);

   typedef struct packed {
      logic        close;
      logic [31:0] id;
      logic [3:0]  flg;
      logic [7:0]  seed;
      logic        exp_rsp;
      logic        exp_hit;
      logic [3:0]  stall;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 32'h11223344, 4'b1110, 8'hA1, 1'b1, 1'b1, 4'd0},
      '{1'b0, 32'h00000005, 4'b1111, 8'h3C, 1'b1, 1'b1, 4'd5},
      '{1'b0, 32'h11223344, 4'b0110, 8'h77, 1'b1, 1'b1, 4'd2},
      '{1'b1, 32'h00000005, 4'h0,    8'h00, 1'b0, 1'b0, 4'd0},
      '{1'b1, 32'hDEAD0000, 4'h0,    8'h00, 1'b0, 1'b0, 4'd0},
      '{1'b0, 32'hCAFEF00D, 4'b1010, 8'h09, 1'b1, 1'b1, 4'd3}
   };

   function automatic logic [7:0] pb(input logic [7:0] seed, input logic [3:0] flg, input int p);
      if (p == 19) return {4'h0, flg};
      if (p == 59) return {4'h3, seed[3:0]};
      return seed + 8'(p * 7);
   endfunction

   function automatic logic [255:0] fld(input logic [7:0] seed, input logic [3:0] flg,
                                        input int off, input int len);
      logic [255:0] r = '0;
      for (int k = 0; k < len; k++) r = {r[247:0], pb(seed, flg, off + k)};
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [511:0] act,
                      input logic [511:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input logic last);
      @(negedge clk);
      in_valid = 1'b1; in_data = b; in_last = last;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
   endtask

   task automatic idle_in();
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic send_open(input logic [31:0] id, input logic [3:0] flg,
                            input logic [7:0] seed, input int stop_at);
      for (int n = 0; n < 153; n++) begin
         logic [7:0] b;
         logic       l;
         b = (n == 0) ? 8'h01 : (n < 5) ? id[8*(4-n) +: 8] : pb(seed, flg, n - 5);
         l = (n == 152) || (n == stop_at);
         send_byte(b, l);
         if (l) break;
      end
      idle_in();
   endtask

   task automatic send_close(input logic [31:0] id);
      send_byte(8'h02, 1'b0);
      for (int n = 1; n < 5; n++) send_byte(id[8*(4-n) +: 8], n == 4);
      idle_in();
   endtask

   task automatic get_rsp(input logic [31:0] id, input int stall, input string req);
      bit ok = 1'b1;
      logic [8:0] act_b, exp_b;
      logic [8:0] bad_a = '0, bad_e = '0;
      for (int k = 0; k < 8; k++) begin
         int wt = 0;
         @(negedge clk);
         rsp_ready = 1'b0;
         while (!rsp_valid && wt < 50) begin @(negedge clk); wt++; end
         if (k == 0 && stall > 0) begin
            logic [7:0] d0 = rsp_data;
            bit sok = 1'b1;
            for (int s = 0; s < stall; s++) begin
               @(negedge clk);
               sok &= rsp_valid && (rsp_data == d0) && !rsp_last && !in_ready;
            end
            chk(sok, "R4 byte held and input stalled", {503'd0, sok}, 512'd1);
         end
         exp_b = {k == 7, (k < 3) ? 8'h00 : (k == 3) ? 8'h81 : id[8*(7-k) +: 8]};
         act_b = {rsp_last, rsp_data};
         if (!rsp_valid || act_b != exp_b) begin ok = 1'b0; bad_a = act_b; bad_e = exp_b; end
         rsp_ready = 1'b1;
      end
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(ok, req, {503'd0, bad_a}, {503'd0, bad_e});
   endtask

   task automatic no_rsp(input string req);
      bit seen = 1'b0;
      for (int k = 0; k < 12; k++) begin @(negedge clk); seen |= rsp_valid; end
      chk(!seen, req, {511'd0, seen}, 512'd0);
   endtask

   task automatic check_lookup(input logic [31:0] id, input logic exp_hit,
                               input logic [7:0] seed, input logic [3:0] flg);
      logic [447:0] a, e;
      @(negedge clk);
      lk_id = id;
      #1;
      chk(lk_hit == exp_hit, "R1 lookup hit", {511'd0, lk_hit}, {511'd0, exp_hit});
      if (exp_hit) begin
         chk(lk_flags == flg, "R10 flags nibble", {508'd0, lk_flags}, {508'd0, flg});
         chk(lk_tls_ver == 4'h3, "R10 version nibble", {508'd0, lk_tls_ver}, 512'd3);
         a = {lk_src_port, lk_dst_port, lk_tcp_sn, lk_rec_sn, lk_next_sn, lk_iv, lk_key};
         e = {fld(seed, flg, 20, 2)[15:0], fld(seed, flg, 22, 2)[15:0],
              fld(seed, flg, 28, 4)[31:0], fld(seed, flg, 48, 8)[63:0],
              fld(seed, flg, 60, 4)[31:0], fld(seed, flg, 64, 4)[31:0],
              fld(seed, flg, 116, 32)};
         chk(a == e, "R2 stored fields", {64'd0, a}, {64'd0, e});
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   initial begin
      do_reset();
      #1;
      // R11 reset state
      chk(in_ready && !rsp_valid && !err_full && !err_unknown_id && !err_msg && !lk_hit,
          "R11 reset state",
          {506'd0, in_ready, rsp_valid, err_full, err_unknown_id, err_msg, lk_hit},
          {506'd0, 6'b100000});

      // vector table walk
      foreach (VECS[i]) begin
         if (VECS[i].close) begin
            send_close(VECS[i].id);
            no_rsp("R5 close sends no acknowledgement");
         end else begin
            send_open(VECS[i].id, VECS[i].flg, VECS[i].seed, -1);
            get_rsp(VECS[i].id, int'(VECS[i].stall), "R3 acknowledgement bytes");
         end
         check_lookup(VECS[i].id, VECS[i].exp_hit, VECS[i].seed, VECS[i].flg);
      end
      #1;
      chk(err_unknown_id, "R8 unknown close flagged", {511'd0, err_unknown_id}, 512'd1);
      chk(!err_full && !err_msg, "R6 no spurious errors", {510'd0, err_full, err_msg}, 512'd0);

      // fill: 2 entries used, 6 more fill the table exactly if overwrite reused its slot
      for (int j = 0; j < 6; j++) begin
         send_open(32'h100 + j, 4'b1100, 8'(8'h40 + j), -1);
         get_rsp(32'h100 + j, 0, "R3 fill acknowledgement");
      end
      #1;
      chk(!err_full, "R6 overwrite kept one slot", {511'd0, err_full}, 512'd0);
      send_open(32'h200, 4'b1000, 8'h5A, -1);
      get_rsp(32'h200, 0, "R7 acknowledgement when full");
      #1;
      chk(err_full, "R7 full flag", {511'd0, err_full}, 512'd1);
      check_lookup(32'h200, 1'b0, 8'h00, 4'h0);
      check_lookup(32'h105, 1'b1, 8'h45, 4'b1100);
      check_lookup(32'h11223344, 1'b1, 8'h77, 4'b0110);

      // R9 bad command code drained, next message parsed
      send_byte(8'h07, 1'b0);
      send_byte(8'h01, 1'b0);
      send_byte(8'h02, 1'b0);
      send_byte(8'h03, 1'b1);
      idle_in();
      no_rsp("R9 bad code sends nothing");
      chk(err_msg, "R9 message error flag", {511'd0, err_msg}, 512'd1);
      send_close(32'h100);
      check_lookup(32'h100, 1'b0, 8'h00, 4'h0);
      check_lookup(32'h101, 1'b1, 8'h41, 4'b1100);

      // R12 early marker
      do_reset();
      #1;
      chk(!err_msg && !err_full && !lk_hit, "R11 reset clears state",
          {509'd0, err_msg, err_full, lk_hit}, 512'd0);
      send_open(32'h77, 4'b1001, 8'h12, 20);
      no_rsp("R12 short open not acknowledged");
      chk(err_msg, "R12 length error flag", {511'd0, err_msg}, 512'd1);
      check_lookup(32'h77, 1'b0, 8'h00, 4'h0);
      send_open(32'h77, 4'b1001, 8'h12, -1);
      get_rsp(32'h77, 1, "R12 recovery acknowledgement");
      check_lookup(32'h77, 1'b1, 8'h12, 4'b1001);

      finish_run();
   end
endmodule